// File: doc/BRIEF.md
# Receive Packet FIFO with Per-Packet Status

This block sits between a receive MAC and a host read port. The MAC side writes packet bytes one per clock, marking the first and last byte of each packet and giving an error code with the last byte. Bytes go into a circular byte store. Each packet also gets an entry in a small status queue, which holds the packet's byte count, its error code and whether it has finished arriving.

The host always sees the oldest packet: its next unread byte and a 16-bit status word. The host pops bytes one at a time. When it is done with the packet, it issues the discard command, which drops whatever is left of the packet and frees its status entry. A receive-reset command empties everything.

Overflow of either store refuses incoming data and sets a flag that clears on its own. Reading past the end of the head packet sets a sticky underrun fault, which is also reported as an adapter failure.

Top module: `rx_pkt_fifo`

## Requirements
- R1: With no packet in the status queue, `head_status` reads 16'h8000 and `rx_complete` is low.
- R2: After an accepted start byte, `rx_receiving` stays high until the end byte. While the head packet is still arriving, `head_status` has bit 15 set, bits 14..11 zero and the running count of stored bytes in bits 10..0.
- R3: For a finished head packet, bit 15 of `head_status` is 0, bits 14..11 hold its 4-bit error code and bits 10..0 its stored byte count. Bit 14 (the top bit of the code) marks an error. Unless R6 or R7 applies, the code is the `wr_err` value given with the end byte.
- R4: `rd_data` shows the next unread byte of the head packet. A pop moves to the following byte, and bytes come out in the order they were written.
- R5: A start byte that arrives while PKT_MAX entries are held is refused together with the whole packet, and `stat_ovr` is set. A discard clears `stat_ovr`.
- R6: A byte that arrives while the store is full, or while `data_ovr` is set, is dropped. A byte arriving while the store is full sets `data_ovr`. Any packet that lost a byte ends with code 1000 (overrun). `data_ovr` clears in the cycle after at least OVR_CLR bytes are free.
- R7: A packet with more than MAX_LEN stored bytes ends with code 1001 (oversize). Overrun takes priority over oversize.
- R8: A pop when the head packet has no unread byte, or when no packet is held, moves nothing. It sets `rx_underrun` and `adapter_fail`, and these stay set until reset or receive-reset.
- R9: Discard (`cmd_op` 5'h08) on a finished head packet drops its unread bytes and its status entry. It has no effect while the head packet is still arriving.
- R10: Receive-reset (`cmd_op` 5'h05) empties the byte store and the status queue, abandons a packet in progress, and clears `stat_ovr`, `data_ovr` and `rx_underrun`. Write bytes in the same cycle are ignored.
- R11: `rx_complete` is high exactly when at least one finished packet is in the status queue.
- R12: A pop in a cycle with `cmd_valid` high is ignored. A byte without the start mark while no packet is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write byte valid |
| wr_sop | input | 1 | Byte is the first of a packet |
| wr_eop | input | 1 | Byte is the last of a packet |
| wr_data | input | 8 | Write byte |
| wr_err | input | 4 | Error code given with the last byte |
| rd_pop | input | 1 | Host pops one byte |
| rd_data | output | 8 | Next unread byte of the head packet |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 5 | Command code (5'h05 receive-reset, 5'h08 discard) |
| head_status | output | 16 | Status word of the head packet |
| rx_complete | output | 1 | At least one finished packet held |
| rx_receiving | output | 1 | Packet being written |
| stat_ovr | output | 1 | Status queue overflow |
| data_ovr | output | 1 | Byte store overflow |
| rx_underrun | output | 1 | Sticky read-past-end fault |
| adapter_fail | output | 1 | Adapter failure indication |

## Verification
The bench builds the block with DEPTH=16, PKT_MAX=8, MAX_LEN=10 and OVR_CLR=4. A 16-byte store lets a single packet fill it, so the overrun code can be checked together with its priority over oversize. A short MAX_LEN makes the oversize code reachable with a 12-byte packet. With PKT_MAX=8, eight one-byte packets fill the status queue long before the store, which isolates status overflow. A randomized phase then mixes writes, pops, discards and resets against the behavioural model.

// File: rtl/rxq_pkg.sv
// Shared types and constants for the receive packet FIFO.
package rxq_pkg;
    localparam int CNT_W = 11;

    localparam logic [3:0] CODE_OVERRUN  = 4'b1000;
    localparam logic [3:0] CODE_OVERSIZE = 4'b1001;

    localparam logic [4:0] OP_RX_RESET = 5'h05;
    localparam logic [4:0] OP_DISCARD  = 5'h08;

    // One status queue entry.
    typedef struct packed {
        logic             done;
        logic [3:0]       code;
        logic [CNT_W-1:0] cnt;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_data_store.sv
// Circular byte store. One byte can be pushed per cycle, and the read pointer
// can move forward by any amount up to the current fill level.
// Assumes DEPTH is a power of two and the caller never overfills the store
// or moves the read pointer past the fill level.
module rxq_data_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int UW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          adv,
    input  logic [UW-1:0] adv_n,
    output logic [DW-1:0] rd_data,
    output logic [UW-1:0] used
);
    localparam logic [UW-1:0] FULL_LVL = UW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;

    // Storage array write.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= push_data;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp   <= '0;
            rp   <= '0;
            used <= '0;
        end else begin
            wp   <= wp + AW'(push);
            rp   <= adv ? rp + AW'(adv_n) : rp;
            used <= used + UW'(push) - (adv ? adv_n : '0);
        end
    end

    assign rd_data = mem[rp];

    p_push_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> (used < FULL_LVL));
    p_adv_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |-> (adv_n <= used));
endmodule

// File: rtl/rxq_status_queue.sv
// Queue of per-packet status entries. The newest entry is the packet that is
// still arriving: it is allocated at the start byte, its count is bumped for
// each stored byte, and it is closed with a code at the end byte.
// Assumes PKT_MAX is a power of two, at least 2.
module rxq_status_queue
    import rxq_pkg::*;
#(
    parameter int PKT_MAX = 8,
    localparam int QW     = $clog2(PKT_MAX),
    localparam int QUW    = QW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           alloc,
    input  logic           bump,
    input  logic           fin,
    input  logic [3:0]     fin_code,
    input  logic           pop,
    output rxq_entry_t     head,
    output logic [QUW-1:0] used,
    output logic [QUW-1:0] n_done
);
    localparam logic [QUW-1:0] FULL_LVL = QUW'(PKT_MAX);

    rxq_entry_t    ent [PKT_MAX];
    logic [QW-1:0] wp, rp, tail;

    assign tail = wp - 1'b1;

    // Entry contents: allocate a fresh entry or update the open tail entry.
    always_ff @(posedge clk) begin
        if (alloc) begin
            ent[wp] <= rxq_entry_t'{done: fin, code: fin_code, cnt: CNT_W'(bump)};
        end else begin
            if (bump) ent[tail].cnt <= ent[tail].cnt + 1'b1;
            if (fin) begin
                ent[tail].done <= 1'b1;
                ent[tail].code <= fin_code;
            end
        end
    end

    // Pointers, occupancy and count of finished entries.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp     <= '0;
            rp     <= '0;
            used   <= '0;
            n_done <= '0;
        end else begin
            wp     <= wp + QW'(alloc);
            rp     <= rp + QW'(pop);
            used   <= used + QUW'(alloc) - QUW'(pop);
            n_done <= n_done + QUW'(fin) - QUW'(pop);
        end
    end

    assign head = ent[rp];

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !clr) |-> (used < FULL_LVL));
    p_pop_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr) |-> (used != '0) && head.done);
    p_tail_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((bump || fin) && !alloc && !clr) |-> (used != '0));
endmodule

// File: rtl/rx_pkt_fifo.sv
// Receive packet FIFO top. It accepts packet bytes, keeps one status entry per
// packet, serves the oldest packet to the host, and handles the discard and
// receive-reset commands, overflow refusal and the sticky underrun fault.
// Assumes DEPTH and PKT_MAX are powers of two and DEPTH < 2048.
module rx_pkt_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int PKT_MAX = 8,
    parameter int MAX_LEN = 1514,
    parameter int OVR_CLR = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic        wr_sop,
    input  logic        wr_eop,
    input  logic [7:0]  wr_data,
    input  logic [3:0]  wr_err,
    input  logic        rd_pop,
    output logic [7:0]  rd_data,
    input  logic        cmd_valid,
    input  logic [4:0]  cmd_op,
    output logic [15:0] head_status,
    output logic        rx_complete,
    output logic        rx_receiving,
    output logic        stat_ovr,
    output logic        data_ovr,
    output logic        rx_underrun,
    output logic        adapter_fail
);
    localparam int UW  = $clog2(DEPTH) + 1;
    localparam int QUW = $clog2(PKT_MAX) + 1;
    localparam logic [UW-1:0]    D_FULL  = UW'(DEPTH);
    localparam logic [UW-1:0]    CLR_LIM = UW'(OVR_CLR);
    localparam logic [QUW-1:0]   Q_FULL  = QUW'(PKT_MAX);
    localparam logic [CNT_W-1:0] LEN_LIM = CNT_W'(MAX_LEN);

    rxq_entry_t       q_head;
    logic [QUW-1:0]   q_used, q_done;
    logic [UW-1:0]    d_used, d_free, adv_n;
    logic             rx_act, pkt_drop;
    logic [CNT_W-1:0] rx_len, rd_cnt, len_next;
    logic             cmd_reset, cmd_disc, wr_go, start, refuse, take, d_full;
    logic             byte_ok, byte_drop, ending, drop_any;
    logic [3:0]       fin_code;
    logic             has_head, pop_req, pop_ok, pop_bad, disc_ok;

    // Command decode and write-side acceptance.
    assign cmd_reset = cmd_valid && (cmd_op == OP_RX_RESET);
    assign cmd_disc  = cmd_valid && (cmd_op == OP_DISCARD);
    assign wr_go     = wr_valid && !cmd_reset;
    assign start     = wr_go && wr_sop && !rx_act;
    assign refuse    = start && (q_used == Q_FULL);
    assign take      = (start && !refuse) || (wr_go && rx_act);
    assign d_full    = (d_used == D_FULL);
    assign d_free    = D_FULL - d_used;
    assign byte_ok   = take && !d_full && !data_ovr;
    assign byte_drop = take && !byte_ok;
    assign ending    = take && wr_eop;
    assign len_next  = (start ? '0 : rx_len) + CNT_W'(byte_ok);
    assign drop_any  = (start ? 1'b0 : pkt_drop) | byte_drop;

    // End-of-packet code: overrun over oversize over the supplied code.
    always_comb begin
        if (drop_any)                fin_code = CODE_OVERRUN;
        else if (len_next > LEN_LIM) fin_code = CODE_OVERSIZE;
        else                         fin_code = wr_err;
    end

    // Read-side decode against the head entry.
    assign has_head = (q_used != '0);
    assign pop_req  = rd_pop && !cmd_valid;
    assign pop_ok   = pop_req && has_head && (rd_cnt < q_head.cnt);
    assign pop_bad  = pop_req && !pop_ok;
    assign disc_ok  = cmd_disc && has_head && q_head.done;
    assign adv_n    = pop_ok ? UW'(1) : UW'(q_head.cnt - rd_cnt);

    rxq_data_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(cmd_reset),
        .push(byte_ok), .push_data(wr_data),
        .adv(pop_ok || disc_ok), .adv_n(adv_n),
        .rd_data(rd_data), .used(d_used)
    );

    rxq_status_queue #(.PKT_MAX(PKT_MAX)) u_stat (
        .clk(clk), .rst_n(rst_n), .clr(cmd_reset),
        .alloc(start && !refuse), .bump(byte_ok), .fin(ending),
        .fin_code(fin_code), .pop(disc_ok),
        .head(q_head), .used(q_used), .n_done(q_done)
    );

    // Packet-in-progress state: active flag, running length, drop marker.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_reset) begin
            rx_act   <= 1'b0;
            rx_len   <= '0;
            pkt_drop <= 1'b0;
        end else begin
            if (ending)                 rx_act <= 1'b0;
            else if (start && !refuse)  rx_act <= 1'b1;
            if (take) begin
                rx_len   <= len_next;
                pkt_drop <= drop_any;
            end
        end
    end

    // Bytes consumed from the head packet.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_reset || disc_ok) rd_cnt <= '0;
        else if (pop_ok)                    rd_cnt <= rd_cnt + 1'b1;
    end

    // Overflow and fault flags.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_reset) begin
            stat_ovr    <= 1'b0;
            data_ovr    <= 1'b0;
            rx_underrun <= 1'b0;
        end else begin
            if (refuse)       stat_ovr <= 1'b1;
            else if (disc_ok) stat_ovr <= 1'b0;
            data_ovr <= (take && d_full) || (data_ovr && (d_free < CLR_LIM));
            if (pop_bad) rx_underrun <= 1'b1;
        end
    end

    // Host-visible status word.
    always_comb begin
        if (!has_head)          head_status = 16'h8000;
        else if (!q_head.done)  head_status = {1'b1, 4'b0000, q_head.cnt};
        else                    head_status = {1'b0, q_head.code, q_head.cnt};
    end

    assign rx_complete  = (q_done != '0);
    assign rx_receiving = rx_act;
    assign adapter_fail = rx_underrun;

    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_underrun && !cmd_reset) |=> rx_underrun);
    p_done_head_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_complete |-> !head_status[15]);
    p_statovr_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_ovr) |-> ($past(q_used) == Q_FULL));
    p_reset_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (head_status == 16'h8000) && !rx_receiving);
endmodule

// File: tb/sim_rx_pkt_fifo.sv
module sim_rx_pkt_fifo;
    localparam int DEPTH = 16, PKT = 8, MAXL = 10, OVR = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_valid = 0, wr_sop = 0, wr_eop = 0, rd_pop = 0, cmd_valid = 0;
    logic [7:0] wr_data = 0;
    logic [3:0] wr_err = 0;
    logic [4:0] cmd_op = 0;
    logic [7:0] rd_data;
    logic [15:0] head_status;
    logic rx_complete, rx_receiving, stat_ovr, data_ovr, rx_underrun, adapter_fail;

    int total = 0, bad = 0;
    bit seen = 0, finished = 0;

    always #10 clk = ~clk;

    rx_pkt_fifo #(.DEPTH(DEPTH), .PKT_MAX(PKT), .MAX_LEN(MAXL), .OVR_CLR(OVR)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sop(wr_sop),
        .wr_eop(wr_eop), .wr_data(wr_data), .wr_err(wr_err), .rd_pop(rd_pop),
        .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .head_status(head_status), .rx_complete(rx_complete),
        .rx_receiving(rx_receiving), .stat_ovr(stat_ovr), .data_ovr(data_ovr),
        .rx_underrun(rx_underrun), .adapter_fail(adapter_fail)
    );

    // Behavioural reference model.
    int mb[$];
    int ec[$];
    int ecode[$];
    bit ed[$];
    int m_rd, m_len;
    bit m_act, m_drop, m_sovr, m_dovr, m_und;

    task automatic mclear();
        mb.delete(); ec.delete(); ecode.delete(); ed.delete();
        m_rd = 0; m_len = 0; m_act = 0; m_drop = 0;
        m_sovr = 0; m_dovr = 0; m_und = 0;
    endtask

    function automatic logic [15:0] exp_head();
        if (ec.size() == 0) return 16'h8000;
        if (!ed[0]) return {5'b10000, 11'(ec[0])};
        return {1'b0, 4'(ecode[0]), 11'(ec[0])};
    endfunction

    function automatic bit exp_cmpl();
        foreach (ed[i]) if (ed[i]) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin : model
        int nb, ne, len_n, code_n, rem;
        bit start, refuse, take, full, bok, ending, drop_n;
        bit pop_req, pop_ok, pop_bad, disc_ok, dn;
        if (!rst_n) begin
            mclear();
            seen = 1;
        end else if (cmd_valid && cmd_op == 5'h05) begin
            mclear();
        end else begin
            nb = mb.size(); ne = ec.size();
            start  = wr_valid && wr_sop && !m_act;
            refuse = start && (ne == PKT);
            take   = (start && !refuse) || (wr_valid && m_act);
            full   = (nb == DEPTH);
            bok    = take && !full && !m_dovr;
            ending = take && wr_eop;
            len_n  = (start ? 0 : m_len) + int'(bok);
            drop_n = (start ? 1'b0 : m_drop) | (take && !bok);
            code_n = drop_n ? 8 : ((len_n > MAXL) ? 9 : int'(wr_err));
            pop_req = rd_pop && !cmd_valid;
            pop_ok  = pop_req && (ne > 0) && (m_rd < ec[0]);
            pop_bad = pop_req && !pop_ok;
            disc_ok = cmd_valid && (cmd_op == 5'h08) && (ne > 0) && ed[0];
            dn = (take && full) || (m_dovr && ((DEPTH - nb) < OVR));
            if (pop_ok) begin void'(mb.pop_front()); m_rd++; end
            if (disc_ok) begin
                rem = ec[0] - m_rd;
                repeat (rem) void'(mb.pop_front());
                void'(ec.pop_front()); void'(ecode.pop_front()); void'(ed.pop_front());
                m_rd = 0;
            end
            if (start && !refuse) begin
                ec.push_back(0); ecode.push_back(0); ed.push_back(0);
            end
            if (bok) begin
                mb.push_back(int'(wr_data));
                ec[ec.size()-1] = ec[ec.size()-1] + 1;
            end
            if (ending) begin
                ed[ed.size()-1] = 1'b1;
                ecode[ecode.size()-1] = code_n;
            end
            if (take) begin m_len = len_n; m_drop = drop_n; end
            if (ending) m_act = 0; else if (start && !refuse) m_act = 1;
            if (refuse) m_sovr = 1; else if (disc_ok) m_sovr = 0;
            m_dovr = dn;
            if (pop_bad) m_und = 1;
        end
    end

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (seen && rst_n) begin
            chk("R3 head_status", head_status, exp_head());
            chk("R11 rx_complete", 16'(rx_complete), 16'(exp_cmpl()));
            chk("R2 rx_receiving", 16'(rx_receiving), 16'(m_act));
            chk("R5 stat_ovr", 16'(stat_ovr), 16'(m_sovr));
            chk("R6 data_ovr", 16'(data_ovr), 16'(m_dovr));
            chk("R8 rx_underrun", 16'(rx_underrun), 16'(m_und));
            chk("R8 adapter_fail", 16'(adapter_fail), 16'(m_und));
            if (mb.size() > 0) chk("R4 rd_data", 16'(rd_data), 16'(mb[0]));
        end
    end

    task automatic beat(bit v, bit s, bit e, logic [7:0] d, logic [3:0] er,
                        bit p, bit cv, logic [4:0] op);
        wr_valid = v; wr_sop = s; wr_eop = e; wr_data = d; wr_err = er;
        rd_pop = p; cmd_valid = cv; cmd_op = op;
        @(negedge clk);
        wr_valid = 0; wr_sop = 0; wr_eop = 0; rd_pop = 0; cmd_valid = 0;
    endtask

    task automatic send_pkt(int len, int base, logic [3:0] er, bit fin);
        for (int i = 0; i < len; i++)
            beat(1, i == 0, fin && (i == len - 1), 8'(base + i), er, 0, 0, 0);
    endtask

    task automatic pops(int n);
        for (int i = 0; i < n; i++) beat(0, 0, 0, 0, 0, 1, 0, 0);
    endtask

    task automatic cmd(logic [4:0] op);
        beat(0, 0, 0, 0, 0, 0, 1, op);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 empty status", head_status, 16'h8000);
        chk("R1 rx_complete low", 16'(rx_complete), 16'h0);

        send_pkt(2, 8'h10, 4'b0000, 0);
        chk("R2 running status", head_status, 16'h8002);
        chk("R2 receiving", 16'(rx_receiving), 16'h1);
        beat(1, 0, 1, 8'h12, 4'b0010, 0, 0, 0);
        chk("R3 dribble code", head_status, 16'h1003);
        chk("R11 complete", 16'(rx_complete), 16'h1);
        for (int i = 0; i < 3; i++) begin
            chk("R4 byte order", 16'(rd_data), 16'(8'h10 + i));
            pops(1);
        end
        pops(1);
        chk("R8 underrun", 16'(rx_underrun), 16'h1);
        chk("R8 adapter_fail", 16'(adapter_fail), 16'h1);
        chk("R8 status kept", head_status, 16'h1003);
        cmd(5'h05);
        chk("R10 underrun cleared", 16'(rx_underrun), 16'h0);
        chk("R10 emptied", head_status, 16'h8000);

        send_pkt(5, 8'h20, 4'b1101, 1);
        chk("R3 crc code", head_status, 16'h6805);
        pops(2);
        send_pkt(2, 8'h30, 4'b0000, 1);
        cmd(5'h08);
        chk("R9 next head", head_status, 16'h0002);
        chk("R9 next byte", 16'(rd_data), 16'h0030);
        pops(2);
        cmd(5'h08);
        chk("R9 queue empty", head_status, 16'h8000);

        send_pkt(3, 8'h40, 4'b0000, 0);
        cmd(5'h08);
        chk("R9 discard ignored", head_status, 16'h8003);
        beat(1, 0, 1, 8'h43, 4'b0000, 0, 0, 0);
        chk("R9 finished", head_status, 16'h0004);
        cmd(5'h08);

        beat(1, 0, 0, 8'h55, 4'b0000, 0, 0, 0);
        chk("R12 stray byte", head_status, 16'h8000);
        chk("R12 not receiving", 16'(rx_receiving), 16'h0);
        send_pkt(2, 8'h60, 4'b0000, 1);
        beat(0, 0, 0, 0, 0, 1, 1, 5'h1F);
        chk("R12 pop blocked", 16'(rd_data), 16'h0060);
        cmd(5'h05);

        send_pkt(12, 8'h70, 4'b0000, 1);
        chk("R7 oversize", head_status, 16'h480C);
        cmd(5'h05);

        for (int k = 0; k < 8; k++) send_pkt(1, k, 4'b0000, 1);
        chk("R5 not yet", 16'(stat_ovr), 16'h0);
        send_pkt(1, 8'h99, 4'b0000, 1);
        chk("R5 stat_ovr set", 16'(stat_ovr), 16'h1);
        cmd(5'h08);
        chk("R5 stat_ovr cleared", 16'(stat_ovr), 16'h0);
        cmd(5'h05);

        send_pkt(20, 8'h80, 4'b0000, 1);
        chk("R6 data_ovr set", 16'(data_ovr), 16'h1);
        chk("R6 overrun over oversize R7", head_status, 16'h4010);
        send_pkt(2, 8'hA0, 4'b0000, 1);
        pops(4);
        beat(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 data_ovr cleared", 16'(data_ovr), 16'h0);
        cmd(5'h08);
        chk("R6 refused packet", head_status, 16'h4000);
        cmd(5'h05);

        for (int i = 0; i < 1500; i++) begin
            int r;
            r = $urandom_range(0, 31);
            beat($urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 4) == 0, 8'($urandom), 4'($urandom),
                 $urandom_range(0, 2) == 0, r < 3,
                 (r == 0) ? 5'h05 : ((r == 1) ? 5'h08 : 5'h1F));
        end

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end
endmodule